// File: doc/BRIEF.md
# DLL Lock Status Sampler With Clock Gating

This block reads the lock status word of each of several memory PHYs whose status registers cannot be trusted while their memory-side clock is running. For one PHY at a time it stops that PHY's bus clock by clearing that PHY's own gate bit, performs a single status read handshake, and turns the clock back on in the same cycle the read completes. It keeps trying, with a fixed pause between attempts, until the word shows every fine-lock bit set.

Once a PHY reports fine lock, its status word is held and its coarse lock count is pulled out of the word and held beside it. The PHYs are visited strictly in index order: PHY 1 is not touched until PHY 0 has locked. When the last PHY is captured the block raises done, and the held values stay put until software-side control pulses start again.

Top module: `lock_sampler`

## Requirements
- R1: After reset every gate bit is 1 (clock running), every read request is 0, done is 0 and all held words and coarse values are 0.
- R2: PHYs are read in ascending index order; no read request goes to PHY 1 before PHY 0 has returned a locked word, and at most one read request is high at a time.
- R3: Gate bit k is 0 in exactly the cycles where read request k is high; all other gate bits stay 1 during that read.
- R4: A returned word is accepted only when both fine-lock bits (bits 1 and 0) are 1; a word with either of them 0 causes a retry of the same PHY.
- R5: After a rejected word the request for the same PHY stays low for exactly RETRY cycles (default 10) before the next attempt.
- R6: The coarse value of a PHY equals bits 8 down to 2 of its accepted word (the word shifted right by 2, 7 bits kept).
- R7: Done rises after the last PHY's word is accepted; each held word then equals the accepted word of that PHY and no read request is high while done is 1.
- R8: A start pulse while a run is in progress is ignored; while done is 1 the held words and coarse values do not change until the next start, and a start pulse clears done on the following cycle and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a sampling run when idle |
| gate_o | output | NPHY | Per-PHY bus clock enable, 0 stops that PHY's clock |
| rd_req_o | output | NPHY | Per-PHY status read request, held until acknowledged |
| rd_ack_i | input | NPHY | Per-PHY read acknowledge, one cycle, data valid with it |
| rd_data_i | input | NPHY*SW | Status words, PHY k in slice k |
| stat_o | output | NPHY*SW | Held accepted status words |
| coarse_o | output | NPHY*CW | Held coarse lock counts |
| done_o | output | 1 | All PHYs captured |

## Verification
The assertions assume each PHY acknowledges only while its own request is high, with a single-cycle acknowledge, and that start is a short pulse rather than a level held through a run. The bench responder models each PHY that way: it raises one acknowledge a fixed latency after seeing its request, drops it on the next cycle, and feeds a scripted number of rejected words before the locked one. Start is always driven as a one-cycle pulse away from the clock edge, including the extra pulse sent in the middle of a run.

// File: rtl/lsamp_pkg.sv
package lsamp_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_READ = 2'd1,
    S_WAIT = 2'd2
  } lsamp_state_t;
endpackage

// File: rtl/lsamp_retry.sv
module lsamp_retry #(
  parameter int unsigned RETRY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(RETRY + 1);

  logic [TW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load_i) begin
      cnt    <= TW'(RETRY - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired_o = active && (cnt == '0);

  // R5: the pause never runs longer than programmed
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= TW'(RETRY - 1)));
  // R5: a new pause is only requested once the previous one is over
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !active);
endmodule

// File: rtl/lsamp_coarse.sv
module lsamp_coarse #(
  parameter int unsigned SW     = 32,
  parameter int unsigned CW     = 7,
  parameter int unsigned CSHIFT = 2
) (
  input  logic [SW-1:0] word_i,
  output logic [CW-1:0] coarse_o
);
  logic [SW-1:0] shifted;
  assign shifted  = word_i >> CSHIFT;
  assign coarse_o = shifted[CW-1:0];
endmodule

// File: rtl/lsamp_hold.sv
module lsamp_hold #(
  parameter int unsigned NPHY      = 2,
  parameter int unsigned SW        = 32,
  parameter int unsigned CW        = 7,
  parameter int unsigned FINE_MASK = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPHY-1:0]    we_i,
  input  logic [SW-1:0]      word_i,
  input  logic [CW-1:0]      coarse_i,
  output logic [NPHY*SW-1:0] words_o,
  output logic [NPHY*CW-1:0] coarses_o
);
  localparam logic [SW-1:0] FMASK = SW'(FINE_MASK);

  for (genvar k = 0; k < NPHY; k++) begin : g_slot
    logic [SW-1:0] w_q;
    logic [CW-1:0] c_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        w_q <= '0;
        c_q <= '0;
      end else if (we_i[k]) begin
        w_q <= word_i;
        c_q <= coarse_i;
      end
    end

    assign words_o[k*SW +: SW]   = w_q;
    assign coarses_o[k*CW +: CW] = c_q;

    // R4: only a fully locked word is ever stored
    a_r4_lock_only: assert property (@(posedge clk) disable iff (rst)
      we_i[k] |-> ((word_i & FMASK) == FMASK));
  end
endmodule

// File: rtl/lock_sampler.sv
module lock_sampler
  import lsamp_pkg::*;
#(
  parameter int unsigned NPHY      = 2,
  parameter int unsigned SW        = 32,
  parameter int unsigned CW        = 7,
  parameter int unsigned CSHIFT    = 2,
  parameter int unsigned FINE_MASK = 3,
  parameter int unsigned RETRY     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  output logic [NPHY-1:0]    gate_o,
  output logic [NPHY-1:0]    rd_req_o,
  input  logic [NPHY-1:0]    rd_ack_i,
  input  logic [NPHY*SW-1:0] rd_data_i,
  output logic [NPHY*SW-1:0] stat_o,
  output logic [NPHY*CW-1:0] coarse_o,
  output logic               done_o
);
  localparam int unsigned    IW    = (NPHY > 1) ? $clog2(NPHY) : 1;
  localparam logic [SW-1:0]  FMASK = SW'(FINE_MASK);
  localparam logic [IW-1:0]  LAST  = IW'(NPHY - 1);

  lsamp_state_t    st;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   idx_nxt;
  logic [NPHY-1:0] gate_q;
  logic [NPHY-1:0] req_q;
  logic            done_q;

  logic [SW-1:0]   cur_word;
  logic            cur_ack;
  logic            fine_ok;
  logic [CW-1:0]   cur_coarse;
  logic [NPHY-1:0] cap_we;
  logic            tmr_load;
  logic            tmr_expired;

  assign idx_nxt  = idx + 1'b1;
  assign cur_word = rd_data_i[int'(idx)*SW +: SW];
  assign cur_ack  = rd_ack_i[idx];
  assign fine_ok  = (cur_word & FMASK) == FMASK;
  assign tmr_load = (st == S_READ) && cur_ack && !fine_ok;

  always_comb begin
    cap_we = '0;
    if (st == S_READ && cur_ack && fine_ok) cap_we[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      idx    <= '0;
      gate_q <= '1;
      req_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_i) begin
            done_q    <= 1'b0;
            idx       <= '0;
            gate_q    <= '1;
            gate_q[0] <= 1'b0;
            req_q     <= '0;
            req_q[0]  <= 1'b1;
            st        <= S_READ;
          end
        end
        S_READ: begin
          if (cur_ack) begin
            gate_q <= '1;
            req_q  <= '0;
            if (fine_ok) begin
              if (idx == LAST) begin
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else begin
                idx             <= idx_nxt;
                gate_q[idx_nxt] <= 1'b0;
                req_q[idx_nxt]  <= 1'b1;
              end
            end else begin
              st <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (tmr_expired) begin
            gate_q[idx] <= 1'b0;
            req_q[idx]  <= 1'b1;
            st          <= S_READ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  lsamp_retry #(.RETRY(RETRY)) u_retry (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  lsamp_coarse #(.SW(SW), .CW(CW), .CSHIFT(CSHIFT)) u_coarse (
    .word_i   (cur_word),
    .coarse_o (cur_coarse)
  );

  lsamp_hold #(.NPHY(NPHY), .SW(SW), .CW(CW), .FINE_MASK(FINE_MASK)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .we_i      (cap_we),
    .word_i    (cur_word),
    .coarse_i  (cur_coarse),
    .words_o   (stat_o),
    .coarses_o (coarse_o)
  );

  assign gate_o   = gate_q;
  assign rd_req_o = req_q;
  assign done_o   = done_q;

  // R3: a stopped clock always has a read in flight
  a_r3_gate_only_when_reading: assert property (@(posedge clk) disable iff (rst)
    ((gate_o | rd_req_o) == '1));
  // R3: a read never happens with its clock running
  a_r3_read_with_gate_off: assert property (@(posedge clk) disable iff (rst)
    ((gate_o & rd_req_o) == '0));
  // R2: one PHY at a time
  a_r2_single_req: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_req_o));
  // R7: nothing is read once the run has finished
  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rd_req_o == '0));
  // R8: results hold until the next start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(stat_o) && $stable(coarse_o)));
endmodule

// File: tb/sim_lock_sampler.sv
module sim_lock_sampler;
  localparam int NPHY  = 2;
  localparam int SW    = 32;
  localparam int CW    = 7;
  localparam int RETRY = 10;
  localparam int LAT   = 2;
  localparam int NV    = 5;

  localparam int          V_F0 [NV] = '{0, 2, 0, 1, 4};
  localparam int          V_F1 [NV] = '{0, 0, 3, 1, 2};
  localparam logic [31:0] V_W0 [NV] = '{32'h0000_0003, 32'h1234_5677, 32'h0000_0083,
                                        32'hFFFF_FFFF, 32'h0000_01FF};
  localparam logic [31:0] V_W1 [NV] = '{32'h0000_01FF, 32'h0000_0007, 32'hABCD_EF0F,
                                        32'h0000_0003, 32'h8000_0027};
  localparam logic [31:0] V_FW [NV] = '{32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_01FD,
                                        32'hFFFF_FFFE, 32'h0000_01FE};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic [NPHY-1:0]    gate_o;
  logic [NPHY-1:0]    rd_req_o;
  logic [NPHY-1:0]    rd_ack_i = '0;
  logic [NPHY*SW-1:0] rd_data_i = '0;
  logic [NPHY*SW-1:0] stat_o;
  logic [NPHY*CW-1:0] coarse_o;
  logic               done_o;

  int checks = 0;
  int failures = 0;

  // bench configuration, written only by the initial block
  int          cfg_f0, cfg_f1;
  logic [31:0] cfg_w0, cfg_w1, cfg_fw;

  // responder state, written only by the responder
  int          left0, left1, att0, att1, lat0, lat1;
  int          gap0, gap1;
  bit          meas0, meas1, locked0, run_active;
  int          gate_viol, order_viol, gap_bad;

  always #2 clk = ~clk;

  lock_sampler u0 (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .gate_o    (gate_o),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .stat_o    (stat_o),
    .coarse_o  (coarse_o),
    .done_o    (done_o)
  );

  // PHY model and protocol monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      left0 = 0; left1 = 0; att0 = 0; att1 = 0; lat0 = 0; lat1 = 0;
      gap0 = 0; gap1 = 0; meas0 = 0; meas1 = 0; locked0 = 0; run_active = 0;
      gate_viol = 0; order_viol = 0; gap_bad = 0;
      rd_ack_i <= '0;
    end else begin
      if (start_i && !run_active) begin
        left0 = cfg_f0; left1 = cfg_f1; att0 = 0; att1 = 0; lat0 = 0; lat1 = 0;
        meas0 = 0; meas1 = 0; locked0 = 0; run_active = 1;
        gate_viol = 0; order_viol = 0; gap_bad = 0;
      end
      if (done_o) run_active = 0;
      for (int k = 0; k < NPHY; k++) begin
        if (gate_o[k] == rd_req_o[k]) gate_viol++;
      end
      if (rd_req_o[1] && !locked0) order_viol++;
      if (meas0) begin
        if (rd_req_o[0]) begin
          if (gap0 != RETRY) gap_bad++;
          meas0 = 0;
        end else gap0++;
      end
      if (meas1) begin
        if (rd_req_o[1]) begin
          if (gap1 != RETRY) gap_bad++;
          meas1 = 0;
        end else gap1++;
      end
      if (rd_ack_i[0]) rd_ack_i[0] <= 1'b0;
      else if (rd_req_o[0]) begin
        if (lat0 == LAT) begin
          lat0 = 0; att0++;
          rd_ack_i[0] <= 1'b1;
          if (left0 > 0) begin
            rd_data_i[0 +: SW] <= cfg_fw; left0--; meas0 = 1; gap0 = 0;
          end else begin
            rd_data_i[0 +: SW] <= cfg_w0; locked0 = 1;
          end
        end else lat0++;
      end
      if (rd_ack_i[1]) rd_ack_i[1] <= 1'b0;
      else if (rd_req_o[1]) begin
        if (lat1 == LAT) begin
          lat1 = 0; att1++;
          rd_ack_i[1] <= 1'b1;
          if (left1 > 0) begin
            rd_data_i[SW +: SW] <= cfg_fw; left1--; meas1 = 1; gap1 = 0;
          end else begin
            rd_data_i[SW +: SW] <= cfg_w1;
          end
        end else lat1++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] cexp(input logic [31:0] w);
    return (w >> 2) & 32'h7F;
  endfunction

  task automatic check_run(input string tag, input int f0, input int f1,
                           input logic [31:0] w0, input logic [31:0] w1);
    chk({tag, " R7 done"}, 32'(done_o), 32'd1);
    chk({tag, " R7 word0"}, stat_o[0 +: SW], w0);
    chk({tag, " R7 word1"}, stat_o[SW +: SW], w1);
    chk({tag, " R6 coarse0"}, 32'(coarse_o[0 +: CW]), cexp(w0));
    chk({tag, " R6 coarse1"}, 32'(coarse_o[CW +: CW]), cexp(w1));
    chk({tag, " R4 attempts0"}, 32'(att0), 32'(f0 + 1));
    chk({tag, " R4 attempts1"}, 32'(att1), 32'(f1 + 1));
    chk({tag, " R3 gate"}, 32'(gate_viol), 32'd0);
    chk({tag, " R2 order"}, 32'(order_viol), 32'd0);
    chk({tag, " R5 gap"}, 32'(gap_bad), 32'd0);
    chk({tag, " R7 no req"}, 32'(rd_req_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfg_f0 = 0; cfg_f1 = 0; cfg_w0 = '0; cfg_w1 = '0; cfg_fw = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk("R1 gate", 32'(gate_o), 32'h3);
    chk("R1 req", 32'(rd_req_o), 32'h0);
    chk("R1 done", 32'(done_o), 32'h0);
    chk("R1 stat0", stat_o[0 +: SW], 32'h0);
    chk("R1 coarse", 32'(coarse_o), 32'h0);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      cfg_f0 = V_F0[v]; cfg_f1 = V_F1[v];
      cfg_w0 = V_W0[v]; cfg_w1 = V_W1[v]; cfg_fw = V_FW[v];
      pulse_start();
      wait_done();
      check_run($sformatf("vec%0d", v), V_F0[v], V_F1[v], V_W0[v], V_W1[v]);
    end

    // R8: held values do not move while done, even if PHY data changes
    cfg_w0 = 32'h5A5A_5A5B; cfg_w1 = 32'hA5A5_A5A7; cfg_f0 = 3; cfg_f1 = 1;
    cfg_fw = 32'h0F0F_0F0D;
    repeat (30) @(negedge clk);
    chk("R8 stable word0", stat_o[0 +: SW], V_W0[NV-1]);
    chk("R8 stable word1", stat_o[SW +: SW], V_W1[NV-1]);
    chk("R8 stable coarse1", 32'(coarse_o[CW +: CW]), cexp(V_W1[NV-1]));

    // R8: start clears done next cycle; second start mid-run is ignored
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    @(negedge clk);
    chk("R8 done cleared", 32'(done_o), 32'd0);
    repeat (8) @(posedge clk);
    #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    wait_done();
    check_run("busy start R8", 3, 1, 32'h5A5A_5A5B, 32'hA5A5_A5A7);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule